// File: doc/BRIEF.md
# Intra 4x4 DC Predictor

This block builds the flat, or DC, prediction for a 4x4 luma block. It takes the four reconstructed samples in the row above the block, the four samples in the column to its left and a small availability flag word. It forms one averaged value from whichever neighbour sets are present and copies that value into all sixteen positions of the prediction block.

A one-cycle `start` pulse captures the result. One clock later the packed block appears with a single-cycle `pred_valid` strobe. The block then holds that result until the next `start`. The averaging divisor and rounding offset depend on which neighbour sets the flags mark as present. A fixed mid-grey value is used when neither set is present. The sample width and the edge length are parameters, and the defaults give 8-bit samples on a 4-sample edge.

Top module: `intra_dc4_pred`

## Requirements
- R1: With both the above flag and the left flag set, the predicted value is (sum of the four above samples + sum of the four left samples + 4) >> 3.
- R2: With only the above flag set, the predicted value is (sum of the four above samples + 2) >> 2.
- R3: With only the left flag set, the predicted value is (sum of the four left samples + 2) >> 2.
- R4: With neither flag set, the predicted value is 128, whatever the neighbour samples hold.
- R5: The value is copied into all sixteen output samples. Row r occupies `pred_rows[32r+31:32r]`, and sample c of a row sits in byte c of that row, so sample 0 is in the least significant byte.
- R6: In `avail`, bit 1 marks the above samples as present and bit 0 marks the left samples as present. Bits 3 and 2 (for example an upper-right flag) have no effect on the result.
- R7: Internal sums cannot overflow. All neighbours at 255 give 255 in every case that uses them, and all neighbours at 0 give 0.
- R8: `pred_valid` is high for exactly the one cycle after a cycle with `start` high. `pred_rows` keeps its value while `start` is low, even when the inputs change.
- R9: A synchronous active-high `rst` clears `pred_valid` and `pred_rows` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Captures the prediction for the current inputs |
| above_px | input | 32 | Four above samples, sample 0 in bits 7:0 |
| left_px | input | 32 | Four left samples, sample 0 in bits 7:0 |
| avail | input | 4 | Availability flags: bit 1 above, bit 0 left, bits 3:2 ignored |
| pred_rows | output | 128 | Four 32-bit prediction rows, row 0 in bits 31:0 |
| pred_valid | output | 1 | One-cycle strobe marking a new result |

## Verification
Each availability combination is driven with graded, asymmetric neighbour values. A wrong divisor, a wrong rounding offset, or a swap of the above and left sets then gives a different value in each case. Sums that land exactly on a rounding boundary separate a missing rounding offset from a correct one. All-255 neighbours expose a sum that is too narrow, and all-0 neighbours expose a stray offset. The extra flag bits are set in every combination to show they change nothing. An unavailable set is filled with values that would shift the average if it were wrongly included.

// File: rtl/intra_dc4_pkg.sv
package intra_dc4_pkg;

   // Availability combination, formed as {above_present, left_present}
   typedef enum logic [1:0] {
      DC_NONE  = 2'b00,
      DC_LEFT  = 2'b01,
      DC_ABOVE = 2'b10,
      DC_BOTH  = 2'b11
   } dc_case_t;

endpackage

// File: rtl/intra_dc4_sum.sv
// Sums NUM_PX samples of PX_W bits into a SUM_W-bit total.
module intra_dc4_sum #(
   parameter int PX_W   = 8,
   parameter int NUM_PX = 4,
   parameter int SUM_W  = 11
) (
   input  logic [NUM_PX*PX_W-1:0] px,
   output logic [SUM_W-1:0]       total
);
   logic [SUM_W-1:0] part [NUM_PX+1];

   assign part[0] = '0;
   for (genvar g = 0; g < NUM_PX; g++) begin : g_acc
      assign part[g+1] = part[g] + SUM_W'(px[g*PX_W +: PX_W]);
   end
   assign total = part[NUM_PX];
endmodule

// File: rtl/intra_dc4_sel.sv
// Chooses divisor and rounding from the availability pair.
module intra_dc4_sel
   import intra_dc4_pkg::*;
#(
   parameter int PX_W  = 8,
   parameter int EDGE  = 4,
   parameter int SUM_W = 11
) (
   input  logic [SUM_W-1:0] sum_above,
   input  logic [SUM_W-1:0] sum_left,
   input  logic             has_above,
   input  logic             has_left,
   output logic [PX_W-1:0]  dc_val
);
   localparam int               LOG_E  = $clog2(EDGE);
   localparam logic [SUM_W-1:0] RND_1  = SUM_W'(EDGE / 2);
   localparam logic [SUM_W-1:0] RND_2  = SUM_W'(EDGE);
   localparam logic [PX_W-1:0]  MID    = {1'b1, {(PX_W-1){1'b0}}};

   dc_case_t         sel;
   logic [SUM_W-1:0] acc;

   assign sel = dc_case_t'({has_above, has_left});

   always_comb begin
      acc    = '0;
      dc_val = MID;
      unique case (sel)
         DC_BOTH: begin
            acc    = sum_above + sum_left + RND_2;
            dc_val = PX_W'(acc >> (LOG_E + 1));
         end
         DC_ABOVE: begin
            acc    = sum_above + RND_1;
            dc_val = PX_W'(acc >> LOG_E);
         end
         DC_LEFT: begin
            acc    = sum_left + RND_1;
            dc_val = PX_W'(acc >> LOG_E);
         end
         default: begin
            acc    = '0;
            dc_val = MID;
         end
      endcase
   end
endmodule

// File: rtl/intra_dc4_rep.sv
// Replicates one value into an EDGE x EDGE block of rows.
module intra_dc4_rep #(
   parameter int PX_W = 8,
   parameter int EDGE = 4
) (
   input  logic [PX_W-1:0]           dc_val,
   output logic [EDGE*EDGE*PX_W-1:0] rows
);
   for (genvar r = 0; r < EDGE; r++) begin : g_row
      for (genvar c = 0; c < EDGE; c++) begin : g_col
         assign rows[(r*EDGE + c)*PX_W +: PX_W] = dc_val;
      end
   end
endmodule

// File: rtl/intra_dc4_pred.sv
module intra_dc4_pred #(
   parameter int PX_W      = 8,
   parameter int EDGE      = 4,
   parameter int FLAG_W    = 4,
   parameter int ABOVE_BIT = 1,
   parameter int LEFT_BIT  = 0
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic                       start,
   input  logic [EDGE*PX_W-1:0]       above_px,
   input  logic [EDGE*PX_W-1:0]       left_px,
   input  logic [FLAG_W-1:0]          avail,
   output logic [EDGE*EDGE*PX_W-1:0]  pred_rows,
   output logic                       pred_valid
);
   localparam int SUM_W = PX_W + $clog2(EDGE) + 1;
   localparam int OUT_W = EDGE * EDGE * PX_W;

   if (EDGE < 2 || (EDGE & (EDGE - 1)) != 0) begin : g_bad_edge
      $error("EDGE must be a power of two of at least 2");
   end
   if (ABOVE_BIT == LEFT_BIT || ABOVE_BIT >= FLAG_W || LEFT_BIT >= FLAG_W) begin : g_bad_flags
      $error("flag bit positions must be distinct and inside FLAG_W");
   end
   if (PX_W < 2) begin : g_bad_px
      $error("PX_W must be at least 2");
   end

   logic [SUM_W-1:0] sum_a, sum_l;
   logic [PX_W-1:0]  dc_val;
   logic [OUT_W-1:0] rows_d, rows_q;
   logic             valid_q;
   logic             unused_flag_bits;

   assign unused_flag_bits = ^avail;

   intra_dc4_sum #(.PX_W(PX_W), .NUM_PX(EDGE), .SUM_W(SUM_W)) u_sum_above (
      .px(above_px), .total(sum_a));
   intra_dc4_sum #(.PX_W(PX_W), .NUM_PX(EDGE), .SUM_W(SUM_W)) u_sum_left (
      .px(left_px), .total(sum_l));

   intra_dc4_sel #(.PX_W(PX_W), .EDGE(EDGE), .SUM_W(SUM_W)) u_sel (
      .sum_above(sum_a), .sum_left(sum_l),
      .has_above(avail[ABOVE_BIT]), .has_left(avail[LEFT_BIT]),
      .dc_val(dc_val));

   intra_dc4_rep #(.PX_W(PX_W), .EDGE(EDGE)) u_rep (
      .dc_val(dc_val), .rows(rows_d));

   always_ff @(posedge clk) begin
      if (rst) begin
         valid_q <= 1'b0;
         rows_q  <= '0;
      end else begin
         valid_q <= start;
         if (start) rows_q <= rows_d;
      end
   end

   assign pred_rows  = rows_q;
   assign pred_valid = valid_q;
endmodule

// File: rtl/intra_dc4_chk.sv
module intra_dc4_chk #(
   parameter int PX_W      = 8,
   parameter int EDGE      = 4,
   parameter int FLAG_W    = 4,
   parameter int ABOVE_BIT = 1,
   parameter int LEFT_BIT  = 0
) (
   input logic                      clk,
   input logic                      rst,
   input logic                      start,
   input logic [FLAG_W-1:0]         avail,
   input logic [EDGE*EDGE*PX_W-1:0] pred_rows,
   input logic                      pred_valid
);
   localparam logic [PX_W-1:0] MID = {1'b1, {(PX_W-1){1'b0}}};

   logic flat;
   always_comb begin
      flat = 1'b1;
      for (int i = 1; i < EDGE*EDGE; i++)
         if (pred_rows[i*PX_W +: PX_W] != pred_rows[PX_W-1:0]) flat = 1'b0;
   end

   p_reset_clear_r9: assert property (@(posedge clk)
      rst |=> (!pred_valid && pred_rows == '0));

   p_valid_follows_start_r8: assert property (@(posedge clk) disable iff (rst)
      start |=> pred_valid);

   p_valid_single_r8: assert property (@(posedge clk) disable iff (rst)
      !start |=> !pred_valid);

   p_hold_rows_r8: assert property (@(posedge clk) disable iff (rst)
      !start |=> $stable(pred_rows));

   p_flat_block_r5: assert property (@(posedge clk) disable iff (rst)
      pred_valid |-> flat);

   p_mid_grey_r4: assert property (@(posedge clk) disable iff (rst)
      (start && !avail[ABOVE_BIT] && !avail[LEFT_BIT]) |=> pred_rows[PX_W-1:0] == MID);
endmodule

bind intra_dc4_pred intra_dc4_chk #(
   .PX_W(PX_W), .EDGE(EDGE), .FLAG_W(FLAG_W),
   .ABOVE_BIT(ABOVE_BIT), .LEFT_BIT(LEFT_BIT)
) u_chk (
   .clk(clk), .rst(rst), .start(start), .avail(avail),
   .pred_rows(pred_rows), .pred_valid(pred_valid)
);

// File: tb/intra_dc4_pred_bench.sv
module intra_dc4_pred_bench;
   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         start = 1'b0;
   logic [31:0]  above_px = '0;
   logic [31:0]  left_px = '0;
   logic [3:0]   avail = '0;
   logic [127:0] pred_rows;
   logic         pred_valid;

   int vectors = 0;
   int errors  = 0;
   logic [127:0] last_exp = '0;

   always #4 clk = ~clk;

   intra_dc4_pred u_intra_dc4_pred (
      .clk(clk), .rst(rst), .start(start), .above_px(above_px),
      .left_px(left_px), .avail(avail), .pred_rows(pred_rows),
      .pred_valid(pred_valid));

   function automatic logic [7:0] ref_dc(logic [31:0] a, logic [31:0] l, logic [3:0] f);
      int sa = 0, sl = 0;
      for (int i = 0; i < 4; i++) begin
         sa += int'(a[i*8 +: 8]);
         sl += int'(l[i*8 +: 8]);
      end
      if (f[1] && f[0]) return 8'((sa + sl + 4) / 8);
      if (f[1])         return 8'((sa + 2) / 4);
      if (f[0])         return 8'((sl + 2) / 4);
      return 8'd128;
   endfunction

   function automatic logic [127:0] pack_rows(logic [7:0] v);
      logic [127:0] r = '0;
      for (int row = 0; row < 4; row++)
         for (int col = 0; col < 4; col++)
            r[row*32 + col*8 +: 8] = v;
      return r;
   endfunction

   task automatic check_vec(string req, logic [127:0] act, logic [127:0] exp);
      vectors++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   task automatic check_bit(string req, logic act, logic exp);
      vectors++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: got %b expected %b", req, act, exp);
      end
   endtask

   task automatic run_case(logic [31:0] a, logic [31:0] l, logic [3:0] f, string req);
      logic [127:0] exp = pack_rows(ref_dc(a, l, f));
      @(negedge clk);
      above_px = a; left_px = l; avail = f; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check_bit({req, " valid"}, pred_valid, 1'b1);
      check_vec(req, pred_rows, exp);
      last_exp = exp;
      @(negedge clk);
      check_bit({req, " R8 strobe width"}, pred_valid, 1'b0);
   endtask

   task automatic t_reset;
      @(negedge clk);
      check_bit("R9 reset valid", pred_valid, 1'b0);
      check_vec("R9 reset rows", pred_rows, '0);
      rst = 1'b0;
   endtask

   task automatic t_both;
      run_case(32'h281E140A, 32'h04030201, 4'b0011, "R1 graded");
      run_case(32'h01000000, 32'h00000002, 4'b0011, "R1 round boundary 3");
      run_case(32'h00000004, 32'h00000000, 4'b0011, "R1 round boundary 4");
      run_case(32'hC8102030, 32'h7F0190FE, 4'b0011, "R1 mixed");
   endtask

   task automatic t_above;
      run_case(32'h281E140A, 32'hFFFFFFFF, 4'b0010, "R2 graded left junk");
      run_case(32'h00000001, 32'h00000000, 4'b0010, "R2 sum 1 rounds to 0");
      run_case(32'h00000002, 32'h00000000, 4'b0010, "R2 sum 2 rounds to 1");
   endtask

   task automatic t_left;
      run_case(32'hFFFFFFFF, 32'h50403020, 4'b0001, "R3 graded above junk");
      run_case(32'h00000000, 32'h00000102, 4'b0001, "R3 sum 3 rounds to 1");
   endtask

   task automatic t_none;
      run_case(32'hFFFFFFFF, 32'h00000000, 4'b0000, "R4 neither");
      run_case(32'h12345678, 32'h9ABCDEF0, 4'b0000, "R4 neither mixed");
   endtask

   task automatic t_extra_bits;
      run_case(32'h281E140A, 32'h04030201, 4'b1111, "R6 both plus extra");
      run_case(32'h281E140A, 32'h04030201, 4'b0110, "R6 above plus bit2");
      run_case(32'h281E140A, 32'h04030201, 4'b1001, "R6 left plus bit3");
      run_case(32'h281E140A, 32'h04030201, 4'b1100, "R6 none plus extra");
   endtask

   task automatic t_extremes;
      run_case(32'hFFFFFFFF, 32'hFFFFFFFF, 4'b0011, "R7 all 255 both");
      run_case(32'hFFFFFFFF, 32'hFFFFFFFF, 4'b0010, "R7 all 255 above");
      run_case(32'hFFFFFFFF, 32'hFFFFFFFF, 4'b0001, "R7 all 255 left");
      run_case(32'h00000000, 32'h00000000, 4'b0011, "R7 all 0 both");
      run_case(32'h00000000, 32'h00000000, 4'b0010, "R7 all 0 above");
   endtask

   task automatic t_hold;
      run_case(32'h0A0A0A0A, 32'h14141414, 4'b0011, "R5 packing");
      @(negedge clk);
      above_px = 32'hFFFFFFFF; left_px = 32'hFFFFFFFF; avail = 4'b0000;
      @(negedge clk);
      @(negedge clk);
      check_vec("R8 hold without start", pred_rows, last_exp);
      check_bit("R8 no strobe without start", pred_valid, 1'b0);
   endtask

   task automatic t_mid_reset;
      run_case(32'h40404040, 32'h40404040, 4'b0011, "R1 before reset");
      @(negedge clk);
      rst = 1'b1;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check_bit("R9 mid reset valid", pred_valid, 1'b0);
      check_vec("R9 mid reset rows", pred_rows, '0);
      rst = 1'b0;
   endtask

   initial begin
      #(200000 * 8);
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

   initial begin
      t_reset();
      t_both();
      t_above();
      t_left();
      t_none();
      t_extra_bits();
      t_extremes();
      t_hold();
      t_mid_reset();
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end
endmodule